// File: doc/BRIEF.md
# Audio Sampling Rate Classifier

This block works out which standard sampling rate an incoming digital audio stream is running at. It counts cycles of a fixed local reference clock between block-start preamble markers, and it sorts the result into one of seven rate bands. The reference clock runs at either 12.288 MHz or 24.576 MHz, and a select input says which.

Measurement starts when the receiver's PLL reports lock. The first block-start pulse after lock opens a cycle window, and the eighth pulse closes it. At that edge the block publishes a 3-bit rate code and drops its error flag. The result then stays frozen until lock goes away. Losing lock clears everything and raises the error flag again. The same result can also be fetched through a small read port.

The preamble pulses must already be one reference-clock cycle wide and synchronous to the reference clock.

Top module: `rate_classifier`

## Requirements
- R1: After reset, `rate_code` is 000, `meas_err` is 1 and `rd_data` is 0x00.
- R2: Rate codes are assigned as follows: 32 kHz gives 001, 44.1 kHz gives 010, 48 kHz gives 011, 88.2 kHz gives 100, 96 kHz gives 101, 176.4 kHz gives 110 and 192 kHz gives 111.
- R3: The measured count C is the number of reference cycles from the first preamble after lock to the eighth. Let K = 7 × FRAMES_PER_BLOCK × 122880. Take each band edge in units of 100 Hz; the band edges are 308–333, 424–458, 462–499, 854–917, 931–990, 1707–1807 and 1862–1981. With `ref_fast`=0 a band matches when floor(K/upper edge) ≤ C ≤ floor(K/lower edge). With `ref_fast`=1 both limits are doubled.
- R4: A count that matches no band produces code 000, and `meas_err` still falls.
- R5: `rate_code` and `meas_err` take their final values in the cycle that follows the clock edge sampling the eighth preamble.
- R6: `meas_err` stays 1, with `rate_code` at 000, from reset or loss of lock until the result is final.
- R7: While lock stays high after a final result, further preambles and changes to `ref_fast` leave `rate_code` and `meas_err` unchanged.
- R8: While `pll_lock` is 0, the next edge clears `rate_code` to 000 and sets `meas_err`, and preambles are ignored. A later lock restarts the count from the first preamble.
- R9: The cycle count saturates at 2^CNT_W−1 rather than wrapping. An overlong window therefore reports 000.
- R10: A clock edge with `rd_en`=1 loads `rd_data` with {0000, meas_err, rate_code} as they stood before that edge. Otherwise `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (12.288 or 24.576 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_fast | input | 1 | 0: reference is 12.288 MHz, 1: reference is 24.576 MHz |
| pll_lock | input | 1 | Receiver PLL lock indication |
| blk_start | input | 1 | One-cycle pulse per block-start preamble |
| rd_en | input | 1 | Read strobe for the result register |
| rate_code | output | 3 | Classified sampling rate (000 = none) |
| meas_err | output | 1 | High until the result is final |
| rd_data | output | 8 | Read data: bit 3 error flag, bits 2:0 rate code |

## Verification
A wrong preamble count shows up as `meas_err` falling one or more cycles away from the eighth pulse. A wrong or wrapped cycle count shows up as the wrong code in exactly that cycle. Both are visible the cycle after the closing pulse. Stale state after a lock loss is caught the next cycle, when code and flag must already be cleared. Stale state is also caught one train later, as an early or late result. Boundary counts placed exactly on and one past a band limit expose off-by-one errors in the limits and in the window length.

// File: rtl/rate_cls_pkg.sv
package rate_cls_pkg;

  localparam int NUM_BANDS   = 7;
  localparam int NUM_PRE     = 8;
  // 12.288 MHz expressed in 100 Hz units
  localparam longint BASE_REF = 122880;

  // Band edges in 100 Hz units; band b yields code b+1
  function automatic int band_edge(input int b, input bit upper);
    int e;
    case (b)
      0: e = upper ? 333  : 308;
      1: e = upper ? 458  : 424;
      2: e = upper ? 499  : 462;
      3: e = upper ? 917  : 854;
      4: e = upper ? 990  : 931;
      5: e = upper ? 1807 : 1707;
      default: e = upper ? 1981 : 1862;
    endcase
    return e;
  endfunction

  // Cycle-count limit of band b over a window of span_frames frames.
  // The upper count limit comes from the lower rate edge.
  function automatic longint count_limit(input int span_frames, input int b,
                                         input bit upper_cnt, input bit fast_ref);
    longint k;
    longint v;
    k = longint'(span_frames) * BASE_REF;
    v = k / longint'(band_edge(b, !upper_cnt));
    return fast_ref ? 2 * v : v;
  endfunction

endpackage

// File: rtl/rc_pream_seq.sv
module rc_pream_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic lock,
  input  logic pulse,
  output logic start_ev,
  output logic done_ev,
  output logic measuring,
  output logic sealed
);
  import rate_cls_pkg::*;

  logic [3:0] seen_q;

  assign start_ev  = lock && pulse && (seen_q == 4'd0);
  assign done_ev   = lock && pulse && (seen_q == 4'(NUM_PRE - 1));
  assign measuring = (seen_q != 4'd0) && (seen_q < 4'(NUM_PRE));
  assign sealed    = (seen_q == 4'(NUM_PRE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  seen_q <= '0;
    else if (!lock)              seen_q <= '0;
    else if (pulse && !sealed)   seen_q <= seen_q + 4'd1;
  end

  assert_seen_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q <= 4'(NUM_PRE));

  assert_seal_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sealed && lock) |=> sealed);

  assert_unlock_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |=> (seen_q == 4'd0));

endmodule

// File: rtl/rc_cycle_meter.sv
module rc_cycle_meter #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock,
  input  logic             start_ev,
  input  logic             measuring,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic at_max;
  assign at_max = (count == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count <= '0;
    else if (!lock)                count <= '0;
    else if (start_ev)             count <= CNT_W'(1);
    else if (measuring && !at_max) count <= count + CNT_W'(1);
  end

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && measuring && !start_ev && at_max) |=> at_max);

  assert_monotone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && measuring && !start_ev) |=> (count >= $past(count)));

endmodule

// File: rtl/rc_band_match.sv
module rc_band_match #(
  parameter int FRAMES_PER_BLOCK = 192,
  parameter int CNT_W            = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             fast_ref,
  output logic [2:0]       code
);
  import rate_cls_pkg::*;

  localparam int SPAN = (NUM_PRE - 1) * FRAMES_PER_BLOCK;

  logic [NUM_BANDS-1:0] hit;

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
    localparam logic [CNT_W-1:0] LO_S = CNT_W'(count_limit(SPAN, b, 1'b0, 1'b0));
    localparam logic [CNT_W-1:0] HI_S = CNT_W'(count_limit(SPAN, b, 1'b1, 1'b0));
    localparam logic [CNT_W-1:0] LO_F = CNT_W'(count_limit(SPAN, b, 1'b0, 1'b1));
    localparam logic [CNT_W-1:0] HI_F = CNT_W'(count_limit(SPAN, b, 1'b1, 1'b1));
    assign hit[b] = fast_ref ? ((count >= LO_F) && (count <= HI_F))
                             : ((count >= LO_S) && (count <= HI_S));
  end

  always_comb begin
    code = 3'd0;
    for (int b = 0; b < NUM_BANDS; b++) begin
      if (hit[b]) code = 3'(b + 1);
    end
  end

  assert_bands_disjoint_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

endmodule

// File: rtl/rate_classifier.sv
module rate_classifier #(
  parameter int FRAMES_PER_BLOCK = 192,
  parameter int CNT_W            = 22
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_fast,
  input  logic       pll_lock,
  input  logic       blk_start,
  input  logic       rd_en,
  output logic [2:0] rate_code,
  output logic       meas_err,
  output logic [7:0] rd_data
);
  logic             start_ev;
  logic             done_ev;
  logic             measuring;
  logic             sealed;
  logic [CNT_W-1:0] win_count;
  logic [2:0]       band_code;

  rc_pream_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock      (pll_lock),
    .pulse     (blk_start),
    .start_ev  (start_ev),
    .done_ev   (done_ev),
    .measuring (measuring),
    .sealed    (sealed)
  );

  rc_cycle_meter #(.CNT_W(CNT_W)) u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock      (pll_lock),
    .start_ev  (start_ev),
    .measuring (measuring),
    .count     (win_count)
  );

  rc_band_match #(.FRAMES_PER_BLOCK(FRAMES_PER_BLOCK), .CNT_W(CNT_W)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .count    (win_count),
    .fast_ref (ref_fast),
    .code     (band_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_code <= 3'd0;
      meas_err  <= 1'b1;
    end else if (!pll_lock) begin
      rate_code <= 3'd0;
      meas_err  <= 1'b1;
    end else if (done_ev && !sealed) begin
      rate_code <= band_code;
      meas_err  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= 8'h00;
    else if (rd_en) rd_data <= {4'b0000, meas_err, rate_code};
  end

  assert_err_zero_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    meas_err |-> (rate_code == 3'd0));

  assert_final_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_lock && !meas_err) |=> ($stable(rate_code) && !meas_err));

  assert_err_falls_with_seal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(meas_err) |-> sealed);

  assert_unlock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_lock |=> (meas_err && rate_code == 3'd0));

endmodule

// File: tb/rate_classifier_test.sv
module rate_classifier_test;

  localparam int FR    = 4;
  localparam int CW    = 15;
  localparam int SATV  = (1 << CW) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_fast = 1'b0;
  logic       pll_lock = 1'b0;
  logic       blk_start = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] rate_code;
  logic       meas_err;
  logic [7:0] rd_data;

  int vectors = 0;
  int misses  = 0;
  bit ended   = 1'b0;

  always #5 clk = ~clk;

  rate_classifier #(.FRAMES_PER_BLOCK(FR), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .ref_fast(ref_fast), .pll_lock(pll_lock),
    .blk_start(blk_start), .rd_en(rd_en), .rate_code(rate_code),
    .meas_err(meas_err), .rd_data(rd_data)
  );

  // ---------------- behavioural reference model ----------------
  int lo_edge [7] = '{308, 424, 462, 854, 931, 1707, 1862};
  int hi_edge [7] = '{333, 458, 499, 917, 990, 1807, 1981};

  function automatic int classify(input int c, input bit fast);
    int k;
    int mul;
    int res;
    k   = 7 * FR * 122880;
    mul = fast ? 2 : 1;
    res = 0;
    foreach (lo_edge[b]) begin
      if (c >= (k / hi_edge[b]) * mul && c <= (k / lo_edge[b]) * mul) res = b + 1;
    end
    return res;
  endfunction

  longint now_cyc = 0;
  longint first_t = 0;
  int     seen = 0;
  int     m_code = 0;
  bit     m_err = 1'b1;
  int     m_rd = 0;

  always @(posedge clk) begin
    now_cyc++;
    if (!rst_n) begin
      seen = 0; m_code = 0; m_err = 1'b1; m_rd = 0;
    end else begin
      if (rd_en) m_rd = (int'(m_err) << 3) | m_code;
      if (!pll_lock) begin
        seen = 0; m_code = 0; m_err = 1'b1;
      end else if (blk_start && seen < 8) begin
        if (seen == 0) first_t = now_cyc;
        seen++;
        if (seen == 8) begin
          longint d;
          d = now_cyc - first_t;
          if (d > SATV) d = SATV;
          m_code = classify(int'(d), ref_fast);
          m_err  = 1'b0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      vectors++;
      if (int'(rate_code) != m_code) begin
        misses++;
        $display("FAIL R3 cycle %0d: rate_code=%0d expected %0d", now_cyc, rate_code, m_code);
      end
      vectors++;
      if (meas_err != m_err) begin
        misses++;
        $display("FAIL R6 cycle %0d: meas_err=%0b expected %0b", now_cyc, meas_err, m_err);
      end
      vectors++;
      if (int'(rd_data) != m_rd) begin
        misses++;
        $display("FAIL R10 cycle %0d: rd_data=%0h expected %0h", now_cyc, rd_data, m_rd);
      end
    end
  end

  // ---------------- directed checks ----------------
  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Eight preambles, gaps "gap" except the last one "last_gap"
  task automatic train(input int gap, input int last_gap, input int expc, input string tag);
    for (int i = 0; i < 8; i++) begin
      if (i == 7) chk("R6 err before final", int'(meas_err), 1);
      blk_start = 1'b1;
      @(negedge clk);
      blk_start = 1'b0;
      if (i == 7) begin
        chk({tag, " code"}, int'(rate_code), expc);
        chk("R5 err drops with result", int'(meas_err), 0);
      end else begin
        repeat (((i == 6) ? last_gap : gap) - 1) @(negedge clk);
      end
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic relock(input bit fast);
    pll_lock = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 code cleared", int'(rate_code), 0);
    chk("R8 err raised", int'(meas_err), 1);
    ref_fast = fast;
    pll_lock = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_read(input int exp, input string tag);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(tag, int'(rd_data), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset code", int'(rate_code), 0);
    chk("R1 reset err", int'(meas_err), 1);
    chk("R1 reset rd_data", int'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // 48 kHz at 12.288 MHz: 1024 cycles per preamble
    ref_fast = 1'b0;
    pll_lock = 1'b1;
    repeat (4) @(negedge clk);
    train(1024, 1024, 3, "R2 48k");

    // R7: more preambles and a select change leave the result alone
    for (int i = 0; i < 5; i++) begin
      blk_start = 1'b1; @(negedge clk); blk_start = 1'b0;
      repeat (299) @(negedge clk);
    end
    ref_fast = 1'b1;
    repeat (5) @(negedge clk);
    chk("R7 code held", int'(rate_code), 3);
    chk("R7 err held", int'(meas_err), 0);

    // R10: read port
    do_read(8'h03, "R10 read final");
    repeat (6) @(negedge clk);
    chk("R10 rd_data held", int'(rd_data), 8'h03);

    // R8: preambles ignored while unlocked
    relock(1'b0);
    pll_lock = 1'b0;
    repeat (2) @(negedge clk);
    do_read(8'h08, "R10 read while error");
    for (int i = 0; i < 4; i++) begin
      blk_start = 1'b1; @(negedge clk); blk_start = 1'b0;
      repeat (50) @(negedge clk);
    end
    chk("R8 err while unlocked", int'(meas_err), 1);

    // 192 kHz at 24.576 MHz
    relock(1'b1);
    train(512, 512, 7, "R2 192k");
    // 96 kHz and 88.2 kHz at 24.576 MHz
    relock(1'b1);
    train(1024, 1024, 5, "R2 96k fast");
    relock(1'b1);
    train(1115, 1115, 4, "R2 88k2 fast");
    // 44.1, 32, 176.4 kHz at 12.288 MHz
    relock(1'b0);
    train(1115, 1115, 2, "R2 44k1");
    relock(1'b0);
    train(1536, 1536, 1, "R2 32k");
    relock(1'b0);
    train(279, 279, 6, "R2 176k4");

    // R3 boundaries: 7447 is the top of the 48k band, 7448 matches nothing
    relock(1'b0);
    train(1064, 1063, 3, "R3 upper limit");
    relock(1'b0);
    train(1064, 1064, 0, "R4 just outside");
    // R3 lower limit 6895 in, 6894 out
    relock(1'b0);
    train(985, 985, 3, "R3 lower limit");
    relock(1'b0);
    train(985, 984, 0, "R4 below lower");

    // R9: 47103 cycles would wrap into the 48k fast band; must saturate
    relock(1'b1);
    train(6729, 6729, 0, "R9 saturation");

    // R8: lock lost mid-measurement restarts the window
    relock(1'b0);
    for (int i = 0; i < 3; i++) begin
      blk_start = 1'b1; @(negedge clk); blk_start = 1'b0;
      repeat (499) @(negedge clk);
    end
    relock(1'b0);
    train(1024, 1024, 3, "R8 restart after loss");

    ended = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      vectors++;
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule